// File: doc/BRIEF.md
# Byte-Latched Program Counter

This block holds the 21-bit fetch address of an 8-bit processor core. The address counts bytes. Bit 0 is always zero, so each sequential step moves the address forward by two. Software sees the counter through an 8-bit register port that exposes three locations: the low byte of the counter, a high holding latch and an upper holding latch. Bits 15:8 and 20:16 of the counter cannot be read or written directly.

The latches move data as a side effect of low-byte accesses. A write to the low byte loads bits 20:8 of the counter from the two latches in the same step. A read of the low byte copies bits 20:8 of the counter into the latches. Call, goto and branch targets arrive on a separate direct-load port. A direct load writes the counter without touching the latches. A sequential-advance input steps the counter between loads.

Register selection codes on `reg_sel`: 0 = counter low byte, 1 = high latch, 2 = upper latch, 3 = no register. Reads are combinational. Writes and latch captures take effect at the next rising clock edge.

Top module: `latched_pc`

## Requirements
- R1: While `rst` is high at a clock edge, the counter and both latches clear to zero. After reset, `fetch_addr` reads 0 and both latches read back as 0.
- R2: Bit 0 of `fetch_addr` is always 0. Bit 0 of any written low byte and bit 0 of any direct-load value are discarded.
- R3: When `advance` is the only active update in a cycle, `fetch_addr` equals the old value plus 2, modulo 2^21, after the next edge. 0x1FFFFE advances to 0.
- R4: A write with `reg_sel`=0 makes `fetch_addr` equal {upper latch, high latch, `reg_wdata`[7:1], 0} after the next edge.
- R5: A read with `reg_sel`=0 shows `fetch_addr`[7:0] on `reg_rdata` in the same cycle. After the next edge, the high latch holds `fetch_addr`[15:8] and the upper latch holds `fetch_addr`[20:16], both taken from the read cycle.
- R6: A write with `reg_sel`=1 loads `reg_wdata` into the high latch. A write with `reg_sel`=2 loads `reg_wdata`[4:0] into the upper latch. Neither write changes `fetch_addr`.
- R7: A read with `reg_sel`=1 returns the high latch in the same cycle. A read with `reg_sel`=2 returns {3'b000, upper latch} in the same cycle. Latch reads change no state.
- R8: With `jump_en` high and no low-byte write, `fetch_addr` becomes {`jump_addr`[20:1], 0} after the next edge. Direct loads and advances leave both latches unchanged.
- R9: Priority is fixed: a low-byte write wins over a direct load, and a direct load wins over an advance.
- R10: If `reg_wr` and `reg_rd` are high together, only the write is performed and no read capture occurs. With `reg_sel`=3, reads return 0 and writes change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 2 | Register select: 0 low byte, 1 high latch, 2 upper latch, 3 none |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational |
| advance | input | 1 | Step the counter by two |
| jump_en | input | 1 | Direct-load strobe |
| jump_addr | input | 21 | Direct-load target |
| fetch_addr | output | 21 | Current fetch address |

## Verification
Read data is combinational, so the bench samples it during the access cycle, before the edge. Counter and latch updates appear one edge after the stimulus. The bench drives inputs 1 ns after a rising edge, then waits for the next edge plus 1 ns before it samples `fetch_addr` or reads back the latches. A latch capture caused by a low-byte read is observed the same way: the bench reads the latch back in the cycle after the capture.

// File: rtl/pcl_pkg.sv
package pcl_pkg;

    localparam int PC_W   = 21;
    localparam int LO_W   = 8;
    localparam int HI_W   = 8;
    localparam int UP_W   = PC_W - LO_W - HI_W;
    localparam int DATA_W = 8;
    localparam int STEP   = 2;

    typedef enum logic [1:0] {
        SEL_LO   = 2'd0,
        SEL_HI   = 2'd1,
        SEL_UP   = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        SRC_HOLD,
        SRC_ADV,
        SRC_JUMP,
        SRC_LOWWR
    } pc_src_e;

    typedef struct packed {
        logic [UP_W-1:0] up;
        logic [HI_W-1:0] hi;
        logic [LO_W-1:0] lo;
    } pc_fields_t;

    function automatic logic [PC_W-1:0] force_even(input logic [PC_W-1:0] a);
        return {a[PC_W-1:1], 1'b0};
    endfunction

endpackage

// File: rtl/pcl_latch_bank.sv
module pcl_latch_bank
    import pcl_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [1:0]           sel,
    input  logic                 wr,
    input  logic                 rd,
    input  logic [DATA_W-1:0]    wdata,
    input  pc_fields_t           pc_q,
    output logic [DATA_W-1:0]    rdata,
    output logic [HI_W-1:0]      lat_hi,
    output logic [UP_W-1:0]      lat_up,
    output logic                 low_wr,
    output logic                 low_rd
);

    reg_sel_e sel_e;
    logic     rd_eff;

    assign sel_e  = reg_sel_e'(sel);
    assign rd_eff = rd && !wr;
    assign low_wr = wr && (sel_e == SEL_LO);
    assign low_rd = rd_eff && (sel_e == SEL_LO);

    always_ff @(posedge clk) begin
        if (rst) begin
            lat_hi <= '0;
            lat_up <= '0;
        end else if (low_rd) begin
            lat_hi <= pc_q.hi;
            lat_up <= pc_q.up;
        end else if (wr && sel_e == SEL_HI) begin
            lat_hi <= wdata[HI_W-1:0];
        end else if (wr && sel_e == SEL_UP) begin
            lat_up <= wdata[UP_W-1:0];
        end
    end

    always_comb begin
        unique case (sel_e)
            SEL_LO:  rdata = pc_q.lo;
            SEL_HI:  rdata = lat_hi;
            SEL_UP:  rdata = DATA_W'(lat_up);
            default: rdata = '0;
        endcase
    end

    p_capture_r5: assert property (@(posedge clk) disable iff (rst)
        (rd && !wr && sel == 2'd0) |=> (lat_hi == $past(pc_q.hi) && lat_up == $past(pc_q.up)));

    p_latch_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!wr && !rd) |=> ($stable(lat_hi) && $stable(lat_up)));

    p_none_sel_r10: assert property (@(posedge clk) disable iff (rst)
        (sel == 2'd3) |=> ($stable(lat_hi) && $stable(lat_up)));

endmodule

// File: rtl/pcl_next_sel.sv
module pcl_next_sel
    import pcl_pkg::*;
(
    input  pc_fields_t           pc_q,
    input  logic                 low_wr,
    input  logic [DATA_W-1:0]    wdata,
    input  logic [HI_W-1:0]      lat_hi,
    input  logic [UP_W-1:0]      lat_up,
    input  logic                 jump_en,
    input  logic [PC_W-1:0]      jump_addr,
    input  logic                 advance,
    output pc_fields_t           pc_d,
    output pc_src_e              src
);

    always_comb begin
        if (low_wr)       src = SRC_LOWWR;
        else if (jump_en) src = SRC_JUMP;
        else if (advance) src = SRC_ADV;
        else              src = SRC_HOLD;
    end

    always_comb begin
        unique case (src)
            SRC_LOWWR: begin
                pc_d.up = lat_up;
                pc_d.hi = lat_hi;
                pc_d.lo = {wdata[LO_W-1:1], 1'b0};
            end
            SRC_JUMP: pc_d = force_even(jump_addr);
            SRC_ADV:  pc_d = force_even(pc_q + PC_W'(STEP));
            default:  pc_d = pc_q;
        endcase
    end

endmodule

// File: rtl/pcl_pc_reg.sv
module pcl_pc_reg
    import pcl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  pc_fields_t pc_d,
    output pc_fields_t pc_q
);

    always_ff @(posedge clk) begin
        if (rst) pc_q <= '0;
        else     pc_q <= force_even(pc_d);
    end

endmodule

// File: rtl/latched_pc.sv
module latched_pc
    import pcl_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [1:0]           reg_sel,
    input  logic                 reg_wr,
    input  logic                 reg_rd,
    input  logic [DATA_W-1:0]    reg_wdata,
    output logic [DATA_W-1:0]    reg_rdata,
    input  logic                 advance,
    input  logic                 jump_en,
    input  logic [PC_W-1:0]      jump_addr,
    output logic [PC_W-1:0]      fetch_addr
);

    pc_fields_t      pc_q;
    pc_fields_t      pc_d;
    pc_src_e         src;
    logic [HI_W-1:0] lat_hi;
    logic [UP_W-1:0] lat_up;
    logic            low_wr;
    logic            low_rd;

    pcl_latch_bank u_bank (
        .clk    (clk),
        .rst    (rst),
        .sel    (reg_sel),
        .wr     (reg_wr),
        .rd     (reg_rd),
        .wdata  (reg_wdata),
        .pc_q   (pc_q),
        .rdata  (reg_rdata),
        .lat_hi (lat_hi),
        .lat_up (lat_up),
        .low_wr (low_wr),
        .low_rd (low_rd)
    );

    pcl_next_sel u_next (
        .pc_q      (pc_q),
        .low_wr    (low_wr),
        .wdata     (reg_wdata),
        .lat_hi    (lat_hi),
        .lat_up    (lat_up),
        .jump_en   (jump_en),
        .jump_addr (jump_addr),
        .advance   (advance),
        .pc_d      (pc_d),
        .src       (src)
    );

    pcl_pc_reg u_reg (
        .clk  (clk),
        .rst  (rst),
        .pc_d (pc_d),
        .pc_q (pc_q)
    );

    assign fetch_addr = pc_q;

    p_even_r2: assert property (@(posedge clk) disable iff (rst)
        fetch_addr[0] == 1'b0);

    p_advance_r3: assert property (@(posedge clk) disable iff (rst)
        (advance && !jump_en && !(reg_wr && reg_sel == 2'd0))
        |=> fetch_addr == $past(fetch_addr) + PC_W'(STEP));

    p_lowwr_r4: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_sel == 2'd0)
        |=> fetch_addr == {$past(lat_up), $past(lat_hi), $past(reg_wdata[7:1]), 1'b0});

    p_latchwr_r6: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_sel != 2'd0 && !jump_en && !advance) |=> $stable(fetch_addr));

    p_jump_r8: assert property (@(posedge clk) disable iff (rst)
        (jump_en && !(reg_wr && reg_sel == 2'd0))
        |=> fetch_addr == {$past(jump_addr[PC_W-1:1]), 1'b0});

    p_src_onehot_r9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({low_wr && src == SRC_LOWWR, !low_wr && src == SRC_LOWWR}) && (low_wr -> src == SRC_LOWWR));

endmodule

// File: tb/latched_pc_tb_top.sv
module latched_pc_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  reg_sel;
    logic        reg_wr;
    logic        reg_rd;
    logic [7:0]  reg_wdata;
    logic [7:0]  reg_rdata;
    logic        advance;
    logic        jump_en;
    logic [20:0] jump_addr;
    logic [20:0] fetch_addr;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    latched_pc dut_i (
        .clk        (clk),
        .rst        (rst),
        .reg_sel    (reg_sel),
        .reg_wr     (reg_wr),
        .reg_rd     (reg_rd),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .advance    (advance),
        .jump_en    (jump_en),
        .jump_addr  (jump_addr),
        .fetch_addr (fetch_addr)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        reg_sel = 2'd3; reg_wr = 0; reg_rd = 0; reg_wdata = 0;
        advance = 0; jump_en = 0; jump_addr = 0;
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic wr_reg(input logic [1:0] s, input logic [7:0] d);
        idle(); reg_sel = s; reg_wr = 1; reg_wdata = d; step(); idle();
    endtask

    task automatic rd_check(input string req, input logic [1:0] s, input logic [7:0] exp);
        idle(); reg_sel = s; reg_rd = 1; #1;
        check(req, reg_rdata, exp);
        step(); idle();
    endtask

    task automatic jump(input logic [20:0] a);
        idle(); jump_en = 1; jump_addr = a; step(); idle();
    endtask

    task automatic t_reset();
        idle(); rst = 1; step(); step(); rst = 0;
        check("R1", fetch_addr, 0);
        rd_check("R1", 2'd1, 8'h00);
        rd_check("R1", 2'd2, 8'h00);
    endtask

    task automatic t_advance();
        idle(); advance = 1; step(); step(); step(); idle();
        check("R3", fetch_addr, 21'h6);
        check("R2", fetch_addr[0], 0);
        jump(21'h1FFFFE);
        advance = 1; step(); idle();
        check("R3 wrap", fetch_addr, 0);
    endtask

    task automatic t_low_write();
        wr_reg(2'd1, 8'h1A);
        check("R6 hi write keeps pc", fetch_addr, 0);
        wr_reg(2'd2, 8'hE3);
        check("R6 up write keeps pc", fetch_addr, 0);
        rd_check("R7 hi", 2'd1, 8'h1A);
        rd_check("R7 up", 2'd2, 8'h03);
        wr_reg(2'd0, 8'h35);
        check("R4 R2", fetch_addr, 21'h031A34);
    endtask

    task automatic t_low_read();
        jump(21'h012345);
        check("R8 R2", fetch_addr, 21'h012344);
        rd_check("R5 rdata", 2'd0, 8'h44);
        rd_check("R5 hi", 2'd1, 8'h23);
        rd_check("R5 up", 2'd2, 8'h01);
        check("R7 no pc change", fetch_addr, 21'h012344);
    endtask

    task automatic t_jump_latches();
        wr_reg(2'd1, 8'h55);
        wr_reg(2'd2, 8'h07);
        jump(21'h1ABCDF);
        check("R8", fetch_addr, 21'h1ABCDE);
        idle(); advance = 1; step(); idle();
        rd_check("R8 hi kept", 2'd1, 8'h55);
        rd_check("R8 up kept", 2'd2, 8'h07);
    endtask

    task automatic t_priority();
        idle(); reg_sel = 2'd0; reg_wr = 1; reg_wdata = 8'h81;
        jump_en = 1; jump_addr = 21'h0F0F0F; advance = 1; step(); idle();
        check("R9 lowwr wins", fetch_addr, 21'h075580);
        idle(); jump_en = 1; jump_addr = 21'h000100; advance = 1; step(); idle();
        check("R9 jump wins", fetch_addr, 21'h000100);
    endtask

    task automatic t_rd_wr_both();
        jump(21'h0A0B0C);
        idle(); reg_sel = 2'd0; reg_wr = 1; reg_rd = 1; reg_wdata = 8'h10; step(); idle();
        check("R10 write done", fetch_addr, 21'h075510);
        rd_check("R10 no capture hi", 2'd1, 8'h55);
        rd_check("R10 no capture up", 2'd2, 8'h07);
        wr_reg(2'd3, 8'hFF);
        rd_check("R10 sel3 reads 0", 2'd3, 8'h00);
        check("R10 sel3 pc", fetch_addr, 21'h075510);
        rd_check("R10 sel3 hi", 2'd1, 8'h55);
    endtask

    initial begin
        idle(); rst = 1;
        t_reset();
        t_advance();
        t_low_write();
        t_low_read();
        t_jump_latches();
        t_priority();
        t_rd_wr_both();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #100000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule